// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor load/store port and a memory that moves whole lines. It keeps one line per index, each with a valid bit, a dirty bit and a tag. Loads and stores that hit are served from the line array alone. A store hit changes only the cached copy and marks the line dirty. Memory sees that data only when the line is later evicted.

On a miss the controller looks at the line it is about to replace. If that line is dirty, the controller first writes the whole line to memory and then fetches the requested line. If the line is clean, the controller fetches the new line straight away. A build-time parameter picks how a store miss is handled. With allocation, the line is fetched and the store bytes are merged into it. Without allocation, only the stored bytes are sent to memory and the cache is left untouched.

The processor holds each request stable until the one-cycle response pulse. The controller works on one request at a time.

Top module: `wb_cache_ctrl`

## Requirements
- R1: A store that hits writes only the cached line. It makes no memory transaction. A later load of the same word returns the stored bytes.
- R2: A store hit, or an allocating store miss, marks the line dirty. When that line is evicted, memory receives the full modified line.
- R3: Before eviction, memory still holds the old contents of a word that was stored to in the cache.
- R4: Evicting a clean line, or filling an invalid one, makes no memory write. The only memory transaction is the line read.
- R5: A load miss reads the whole line from memory before it responds. After that, loads of any other word in the same line hit.
- R6: With WRITE_ALLOC=1, a store miss fetches the line and merges the store bytes into it, with no memory write at that time. Bit reqBe[i] enables data bits [8i+7:8i].
- R7: With WRITE_ALLOC=0, a store miss makes one masked memory write that carries only the enabled bytes of the addressed word. The cache contents are left unchanged.
- R8: On a miss whose victim is dirty, the victim write-back is the first memory transaction. The line read follows it.
- R9: reqReady is high only while idle. A request is taken on a clock edge where reqValid and reqReady are both high. respValid is a single-cycle pulse that returns reqReady high on the next cycle. Request addresses are word aligned.
- R10: After reset every line is invalid, reqReady is high, and respValid and memReq are low.
- R11: A hit raises respValid two clock edges after the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor request present, held until respValid |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Byte address, word aligned |
| reqWdata | input | WORD_W | Store data |
| reqBe | input | WORD_W/8 | Store byte enables |
| reqReady | output | 1 | Controller idle and able to accept a request |
| respValid | output | 1 | One-cycle completion pulse |
| respRdata | output | WORD_W | Load data, valid with respValid |
| memReq | output | 1 | Memory transaction request, held until memAck |
| memWrite | output | 1 | 1 = write, 0 = line read |
| memAddr | output | ADDR_W-OFF_W | Line address |
| memMask | output | LINE_WORDS*WORD_W/8 | Byte write mask for the line |
| memWdata | output | LINE_WORDS*WORD_W | Line write data |
| memRdata | input | LINE_WORDS*WORD_W | Line read data, valid with memAck |
| memAck | input | 1 | One-cycle completion of the memory transaction |

## Verification
A hit shows respValid at the falling edge after the second rising edge, counted from the edge that accepts the request. The driver counts those edges for each request and expects exactly two on a hit and more than two on a miss. The delay of a miss depends on the memory model's fixed acknowledge time and on whether a write-back comes first. For this reason, memory contents and the order of memory transactions are checked only after the response pulse has been seen. Load data is compared by a scoreboard monitor at the same falling edge where respValid is high.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_WRITEBACK,
    ST_REFILL,
    ST_WRITEMEM,
    ST_RESPOND
  } wbc_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture processor request
    logic hitWrite;   // merge store into hit line, set dirty
    logic fillLine;   // install refilled line (merged when a store)
    logic victimSel;  // memory port carries the victim line
  } wbc_strobe_t;

endpackage

// File: rtl/wbc_datapath.sv
module wbc_datapath
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  wbc_strobe_t                         stb,
  input  logic [ADDR_W-1:0]                   reqAddr,
  input  logic                                reqWrite,
  input  logic [WORD_W-1:0]                   reqWdata,
  input  logic [WORD_W/8-1:0]                 reqBe,
  output logic                                hit,
  output logic                                victimDirty,
  output logic                                qWrite,
  output logic [WORD_W-1:0]                   respRdata,
  output logic [ADDR_W-$clog2(LINE_WORDS*WORD_W/8)-1:0] memAddr,
  output logic [LINE_WORDS*WORD_W/8-1:0]      memMask,
  output logic [LINE_WORDS*WORD_W-1:0]        memWdata,
  input  logic [LINE_WORDS*WORD_W-1:0]        memRdata
);

  localparam int BYTES_W = WORD_W / 8;
  localparam int BSEL_W  = $clog2(BYTES_W);
  localparam int WSEL_W  = $clog2(LINE_WORDS);
  localparam int OFF_W   = BSEL_W + WSEL_W;
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W  = LINE_WORDS * WORD_W;
  localparam int LBYTES  = LINE_W / 8;

  logic [ADDR_W-1:0]  qAddr;
  logic [WORD_W-1:0]  qWdata;
  logic [BYTES_W-1:0] qBe;

  logic [LINE_W-1:0] lineData [LINES];
  logic [TAG_W-1:0]  lineTag  [LINES];
  logic [LINES-1:0]  lineValid;
  logic [LINES-1:0]  lineDirty;

  logic [IDX_W-1:0]  qIdx;
  logic [TAG_W-1:0]  qTag;
  logic [WSEL_W-1:0] qWsel;

  assign qIdx  = qAddr[OFF_W +: IDX_W];
  assign qTag  = qAddr[ADDR_W-1 -: TAG_W];
  assign qWsel = qAddr[BSEL_W +: WSEL_W];

  function automatic logic [LINE_W-1:0] mergeStore(
    input logic [LINE_W-1:0]  base,
    input logic [WSEL_W-1:0]  wsel,
    input logic [WORD_W-1:0]  wdata,
    input logic [BYTES_W-1:0] be
  );
    logic [LINE_W-1:0] res;
    res = base;
    for (int w = 0; w < LINE_WORDS; w++) begin
      for (int b = 0; b < BYTES_W; b++) begin
        if (wsel == WSEL_W'(w) && be[b])
          res[w*WORD_W + b*8 +: 8] = wdata[b*8 +: 8];
      end
    end
    return res;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qAddr  <= '0;
      qWrite <= 1'b0;
      qWdata <= '0;
      qBe    <= '0;
    end else if (stb.latchReq) begin
      qAddr  <= reqAddr;
      qWrite <= reqWrite;
      qWdata <= reqWdata;
      qBe    <= reqBe;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineValid <= '0;
      lineDirty <= '0;
    end else if (stb.hitWrite) begin
      lineDirty[qIdx] <= 1'b1;
    end else if (stb.fillLine) begin
      lineValid[qIdx] <= 1'b1;
      lineDirty[qIdx] <= qWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.hitWrite) begin
      lineData[qIdx] <= mergeStore(lineData[qIdx], qWsel, qWdata, qBe);
    end else if (stb.fillLine) begin
      lineData[qIdx] <= qWrite ? mergeStore(memRdata, qWsel, qWdata, qBe) : memRdata;
      lineTag[qIdx]  <= qTag;
    end
  end

  assign hit         = lineValid[qIdx] && (lineTag[qIdx] == qTag);
  assign victimDirty = lineValid[qIdx] && lineDirty[qIdx];
  assign respRdata   = lineData[qIdx][qWsel*WORD_W +: WORD_W];

  always_comb begin
    if (stb.victimSel) begin
      memAddr  = {lineTag[qIdx], qIdx};
      memWdata = lineData[qIdx];
      memMask  = '1;
    end else begin
      memAddr  = qAddr[ADDR_W-1:OFF_W];
      memWdata = {LINE_WORDS{qWdata}};
      for (int w = 0; w < LINE_WORDS; w++)
        for (int b = 0; b < BYTES_W; b++)
          memMask[w*BYTES_W + b] = (qWsel == WSEL_W'(w)) && qBe[b];
    end
  end

  // R1: a store hit leaves its line dirty
  a_r1_hit_marks_dirty: assert property (@(posedge clk) disable iff (!rstN)
    stb.hitWrite |=> lineDirty[$past(qIdx)]);

  // R5: once a line is installed the pending request hits
  a_r5_fill_then_hit: assert property (@(posedge clk) disable iff (!rstN)
    stb.fillLine |=> hit);

  // R9: request addresses are word aligned
  a_r9_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchReq |-> (reqAddr[BSEL_W-1:0] == '0));

  wire unusedBits = ^{LBYTES[0]};

endmodule

// File: rtl/wbc_control.sv
module wbc_control
  import wbc_pkg::*;
#(
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        hit,
  input  logic        victimDirty,
  input  logic        qWrite,
  input  logic        memAck,
  output wbc_strobe_t stb,
  output logic        reqReady,
  output logic        respValid,
  output logic        memReq,
  output logic        memWrite
);

  wbc_state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    reqReady  = 1'b0;
    respValid = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.latchReq = 1'b1;
          nextState    = ST_COMPARE;
        end
      end
      ST_COMPARE: begin
        if (hit) begin
          stb.hitWrite = qWrite;
          nextState    = ST_RESPOND;
        end else if (qWrite && !WRITE_ALLOC) begin
          nextState = ST_WRITEMEM;
        end else if (victimDirty) begin
          nextState = ST_WRITEBACK;
        end else begin
          nextState = ST_REFILL;
        end
      end
      ST_WRITEBACK: begin
        memReq        = 1'b1;
        memWrite      = 1'b1;
        stb.victimSel = 1'b1;
        if (memAck) nextState = ST_REFILL;
      end
      ST_REFILL: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.fillLine = 1'b1;
          nextState    = ST_RESPOND;
        end
      end
      ST_WRITEMEM: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memAck) nextState = ST_RESPOND;
      end
      ST_RESPOND: begin
        respValid = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R8: a refill that replaces a dirty line is preceded by the write-back
  a_r8_writeback_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REFILL && $past(state) != ST_REFILL)
      |-> ($past(state) == ST_WRITEBACK || !$past(victimDirty)));

  // R4: the victim is only written out when dirty
  a_r4_clean_not_written: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && stb.victimSel) |-> victimDirty);

  // R1: a hit produces no memory traffic
  a_r1_hit_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COMPARE && hit) |=> !memReq);

  // R9: response is a single pulse, followed by ready
  a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (!respValid && reqReady));

  // R9: never ready while responding
  a_r9_busy_resp: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !reqReady);

endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int WORD_W      = 32,
  parameter int LINE_WORDS  = 4,
  parameter int LINES       = 8,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                reqValid,
  input  logic                                reqWrite,
  input  logic [ADDR_W-1:0]                   reqAddr,
  input  logic [WORD_W-1:0]                   reqWdata,
  input  logic [WORD_W/8-1:0]                 reqBe,
  output logic                                reqReady,
  output logic                                respValid,
  output logic [WORD_W-1:0]                   respRdata,
  output logic                                memReq,
  output logic                                memWrite,
  output logic [ADDR_W-$clog2(LINE_WORDS*WORD_W/8)-1:0] memAddr,
  output logic [LINE_WORDS*WORD_W/8-1:0]      memMask,
  output logic [LINE_WORDS*WORD_W-1:0]        memWdata,
  input  logic [LINE_WORDS*WORD_W-1:0]        memRdata,
  input  logic                                memAck
);

  wbc_strobe_t stb;
  logic hit, victimDirty, qWrite;

  wbc_control #(.WRITE_ALLOC(WRITE_ALLOC)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit),
    .victimDirty(victimDirty), .qWrite(qWrite), .memAck(memAck),
    .stb(stb), .reqReady(reqReady), .respValid(respValid),
    .memReq(memReq), .memWrite(memWrite)
  );

  wbc_datapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .LINES(LINES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqBe(reqBe),
    .hit(hit), .victimDirty(victimDirty), .qWrite(qWrite),
    .respRdata(respRdata), .memAddr(memAddr), .memMask(memMask),
    .memWdata(memWdata), .memRdata(memRdata)
  );

endmodule

// File: tb/sim_wb_cache_ctrl.sv
module sim_mem #(
  parameter int BLK_W  = 8,
  parameter int LINE_W = 128,
  parameter int DELAY  = 3
) (
  input  logic                clk,
  input  logic                memReq,
  input  logic                memWrite,
  input  logic [BLK_W-1:0]    memAddr,
  input  logic [LINE_W/8-1:0] memMask,
  input  logic [LINE_W-1:0]   memWdata,
  output logic [LINE_W-1:0]   memRdata,
  output logic                memAck
);
  logic [LINE_W-1:0] store [2**BLK_W];
  int  cnt = 0;
  int  opCnt = 0;
  int  wrCount = 0;
  logic       opWr  [16];
  logic [BLK_W-1:0] opBlk [16];

  function automatic logic [31:0] initWord(input int wa);
    return 32'h1000_0000 + 32'(wa) * 32'h0101;
  endfunction

  initial begin
    memAck   = 1'b0;
    memRdata = '0;
    for (int b = 0; b < 2**BLK_W; b++)
      for (int w = 0; w < LINE_W/32; w++)
        store[b][w*32 +: 32] = initWord(b*(LINE_W/32) + w);
  end

  always @(posedge clk) begin
    if (memReq && !memAck) begin
      if (cnt == DELAY-1) begin
        cnt    <= 0;
        memAck <= 1'b1;
        if (opCnt < 16) begin
          opWr[opCnt]  <= memWrite;
          opBlk[opCnt] <= memAddr;
        end
        opCnt <= opCnt + 1;
        if (memWrite) begin
          wrCount <= wrCount + 1;
          for (int i = 0; i < LINE_W/8; i++)
            if (memMask[i]) store[memAddr][i*8 +: 8] <= memWdata[i*8 +: 8];
        end else begin
          memRdata <= store[memAddr];
        end
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      memAck <= 1'b0;
    end
  end
endmodule

module sim_wb_cache_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rstN;

  logic        reqValid [2];
  logic        reqWrite [2];
  logic [11:0] reqAddr  [2];
  logic [31:0] reqWdata [2];
  logic [3:0]  reqBe    [2];
  logic        reqReady [2];
  logic        respValid[2];
  logic [31:0] respRdata[2];
  logic        memReq   [2];
  logic        memWrite [2];
  logic        memAck   [2];
  logic [7:0]  memAddr  [2];
  logic [15:0] memMask  [2];
  logic [127:0] memWdata[2];
  logic [127:0] memRdata[2];

  int checks = 0;
  int failures = 0;
  logic [31:0] shadow [2][1024];
  logic [32:0] expQ0[$];
  logic [32:0] expQ1[$];
  string tagQ0[$];
  string tagQ1[$];

  wb_cache_ctrl #(.WRITE_ALLOC(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[0]), .reqWrite(reqWrite[0]),
    .reqAddr(reqAddr[0]), .reqWdata(reqWdata[0]), .reqBe(reqBe[0]),
    .reqReady(reqReady[0]), .respValid(respValid[0]), .respRdata(respRdata[0]),
    .memReq(memReq[0]), .memWrite(memWrite[0]), .memAddr(memAddr[0]),
    .memMask(memMask[0]), .memWdata(memWdata[0]), .memRdata(memRdata[0]),
    .memAck(memAck[0])
  );
  wb_cache_ctrl #(.WRITE_ALLOC(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[1]), .reqWrite(reqWrite[1]),
    .reqAddr(reqAddr[1]), .reqWdata(reqWdata[1]), .reqBe(reqBe[1]),
    .reqReady(reqReady[1]), .respValid(respValid[1]), .respRdata(respRdata[1]),
    .memReq(memReq[1]), .memWrite(memWrite[1]), .memAddr(memAddr[1]),
    .memMask(memMask[1]), .memWdata(memWdata[1]), .memRdata(memRdata[1]),
    .memAck(memAck[1])
  );

  sim_mem m0 (.clk(clk), .memReq(memReq[0]), .memWrite(memWrite[0]),
    .memAddr(memAddr[0]), .memMask(memMask[0]), .memWdata(memWdata[0]),
    .memRdata(memRdata[0]), .memAck(memAck[0]));
  sim_mem m1 (.clk(clk), .memReq(memReq[1]), .memWrite(memWrite[1]),
    .memAddr(memAddr[1]), .memMask(memMask[1]), .memWdata(memWdata[1]),
    .memRdata(memRdata[1]), .memAck(memAck[1]));

  function automatic logic [31:0] initWord(input int wa);
    return 32'h1000_0000 + 32'(wa) * 32'h0101;
  endfunction

  function automatic logic [31:0] memWord(input int k, input logic [11:0] a);
    if (k == 0) return m0.store[a[11:4]][a[3:2]*32 +: 32];
    else        return m1.store[a[11:4]][a[3:2]*32 +: 32];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReq(input int k, input bit wr, input logic [11:0] a,
                       input logic [31:0] wd, input logic [3:0] be,
                       input string tag, output int lat);
    logic [32:0] ent;
    @(negedge clk);
    if (wr) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) shadow[k][a[11:2]][b*8 +: 8] = wd[b*8 +: 8];
      ent = {1'b1, 32'h0};
    end else begin
      ent = {1'b0, shadow[k][a[11:2]]};
    end
    if (k == 0) begin expQ0.push_back(ent); tagQ0.push_back(tag); end
    else        begin expQ1.push_back(ent); tagQ1.push_back(tag); end
    reqValid[k] = 1'b1; reqWrite[k] = wr; reqAddr[k] = a;
    reqWdata[k] = wd;   reqBe[k] = be;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!respValid[k] && lat < 1000);
    reqValid[k] = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic [32:0] e;
    string t;
    if (rstN && respValid[0]) begin
      if (expQ0.size() == 0) chk(1'b0, "R9 unexpected response u0", 32'h1, 32'h0);
      else begin
        e = expQ0.pop_front(); t = tagQ0.pop_front();
        chk(e[32] || respRdata[0] == e[31:0], t, respRdata[0], e[31:0]);
      end
    end
    if (rstN && respValid[1]) begin
      if (expQ1.size() == 0) chk(1'b0, "R9 unexpected response u1", 32'h1, 32'h0);
      else begin
        e = expQ1.pop_front(); t = tagQ1.pop_front();
        chk(e[32] || respRdata[1] == e[31:0], t, respRdata[1], e[31:0]);
      end
    end
  end

  bit finished = 1'b0;
  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int lat, base, wb;
    for (int k = 0; k < 2; k++) begin
      reqValid[k] = 0; reqWrite[k] = 0; reqAddr[k] = '0;
      reqWdata[k] = '0; reqBe[k] = '0;
      for (int w = 0; w < 1024; w++) shadow[k][w] = initWord(w);
    end
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(reqReady[0] && reqReady[1], "R10 ready after reset", 32'(reqReady[0]), 32'h1);
    chk(!respValid[0] && !respValid[1], "R10 no response in reset", 32'(respValid[0]), 32'h0);
    chk(!memReq[0] && !memReq[1], "R10 no memory request in reset", 32'(memReq[0]), 32'h0);
    rstN = 1'b1;

    // ---------- write-allocate instance ----------
    doReq(0, 0, 12'h010, 0, 0, "R5 load miss data", lat);
    chk(lat > 2, "R10 first load misses", lat, 3);
    chk(m0.wrCount == 0, "R4 fill of invalid line no write", m0.wrCount, 0);
    doReq(0, 0, 12'h01C, 0, 0, "R5 other word of line", lat);
    chk(lat == 2, "R11 hit latency", lat, 2);
    doReq(0, 1, 12'h014, 32'hDEADBEEF, 4'hF, "R1 store hit response", lat);
    chk(lat == 2, "R11 store hit latency", lat, 2);
    chk(m0.wrCount == 0, "R1 store hit no memory write", m0.wrCount, 0);
    doReq(0, 0, 12'h014, 0, 0, "R1 load after store hit", lat);
    chk(memWord(0, 12'h014) == initWord(5), "R3 memory stale before evict",
        memWord(0, 12'h014), initWord(5));

    base = m0.opCnt;
    doReq(0, 0, 12'h094, 0, 0, "R8 load after dirty eviction", lat);
    chk(m0.opCnt == base + 2, "R8 two memory transactions", m0.opCnt - base, 2);
    chk(m0.opWr[base] == 1'b1 && m0.opBlk[base] == 8'h01, "R8 write-back first",
        {m0.opWr[base], 23'h0, m0.opBlk[base]}, {1'b1, 23'h0, 8'h01});
    chk(m0.opWr[base+1] == 1'b0 && m0.opBlk[base+1] == 8'h09, "R8 refill second",
        {m0.opWr[base+1], 23'h0, m0.opBlk[base+1]}, {1'b0, 23'h0, 8'h09});
    chk(memWord(0, 12'h014) == 32'hDEADBEEF, "R2 evicted line reaches memory",
        memWord(0, 12'h014), 32'hDEADBEEF);

    wb = m0.wrCount;
    doReq(0, 0, 12'h114, 0, 0, "R4 load replacing clean line", lat);
    chk(m0.wrCount == wb, "R4 clean eviction no write", m0.wrCount - wb, 0);

    wb = m0.wrCount;
    doReq(0, 1, 12'h208, 32'h11223344, 4'h3, "R6 store miss response", lat);
    chk(lat > 2, "R6 store miss fetches line", lat, 3);
    chk(m0.wrCount == wb, "R6 no write on allocate", m0.wrCount - wb, 0);
    doReq(0, 0, 12'h208, 0, 0, "R6 merged bytes read back", lat);
    chk(lat == 2, "R6 allocated line hits", lat, 2);
    doReq(0, 0, 12'h20C, 0, 0, "R6 neighbour word from memory", lat);
    doReq(0, 0, 12'h288, 0, 0, "R2 load evicting merged line", lat);
    chk(memWord(0, 12'h208) == shadow[0][12'h208 >> 2], "R2 merged line written back",
        memWord(0, 12'h208), shadow[0][12'h208 >> 2]);

    // ---------- no-write-allocate instance ----------
    doReq(1, 0, 12'h030, 0, 0, "R5 u1 load miss", lat);
    wb = m1.wrCount;
    doReq(1, 1, 12'h0B4, 32'hCAFEF00D, 4'hC, "R7 store miss response", lat);
    chk(m1.wrCount == wb + 1, "R7 one memory write", m1.wrCount - wb, 1);
    chk(memWord(1, 12'h0B4) == 32'hCAFE2D2D, "R7 masked bytes in memory",
        memWord(1, 12'h0B4), 32'hCAFE2D2D);
    chk(memWord(1, 12'h0B0) == initWord(12'h2C), "R7 other words untouched",
        memWord(1, 12'h0B0), initWord(12'h2C));
    doReq(1, 0, 12'h030, 0, 0, "R7 resident line kept", lat);
    chk(lat == 2, "R7 cache unchanged by store miss", lat, 2);
    doReq(1, 0, 12'h0B4, 0, 0, "R7 stored word read from memory", lat);
    chk(lat > 2, "R7 stored line not allocated", lat, 3);

    repeat (3) @(negedge clk);
    chk(expQ0.size() == 0 && expQ1.size() == 0, "R9 every request answered",
        expQ0.size() + expQ1.size(), 0);
    finishRun();
  end
endmodule